// File: doc/BRIEF.md
# Base Address Register Bank with Size Masks

This block holds the six 32-bit base address registers of one emulated configuration-space function. Each register slot is set up by static control inputs as unused, an I/O window or a 32-bit memory window. Its size is given as the base-2 log of a port count (I/O) or of a 4 KiB page count (memory), and it also takes a default base. From these the block derives a write mask and a power-up value for every slot. Software writes arrive as a dword index with byte enables. A write burst ends with a write that carries the last-flag.

Bytes are stored raw while a burst is open. In the cycle after the closing write, every slot that took at least one byte is reduced to its mask. In the same step the block issues a one-cycle rebase pulse for that slot, carrying the decoded window base. A sizing probe (all ones) therefore reads back the mask once the burst has closed. A small sequencer with the states IDLE, BURST and APPLY times this: IDLE goes to BURST on a write without last and to APPLY on a write with last. BURST stays in BURST on further non-last writes and goes to APPLY on a last write. APPLY goes to APPLY on a last write, to BURST on a non-last write and to IDLE when no write arrives.

Top module: `bar_bank`

## Requirements
- R1: Slot i (0..5) answers at dword index 4+i on both the write and read side. A read of any other dword index returns 0.
- R2: Kind code 1 is I/O. Its mask is NOT(2^size-1) OR 1, and its reset value is (default AND mask) with bit 0 set.
- R3: Kind code 2 is 32-bit memory. Its mask is NOT(2^(size+12)-1) OR 0xF. Its reset value is default AND mask, with bit 3 (prefetchable) additionally set when the slot's prefetch input is 1.
- R4: Kind codes 0 and 3 mean unused. The reset value and the mask are 0, so any write reads back 0 after the apply step.
- R5: Each written byte lane (wr_be bit b covers bits 8b+7..8b) is stored unmasked. Until the apply step a slot reads back exactly the raw bytes written.
- R6: In the cycle after a write with wr_last (the APPLY state), each slot written since the previous apply is ANDed with its mask and its pending flag is cleared. A write with wr_be of 0, or to an index outside 4..9, marks no slot.
- R7: The apply step raises rebase_vld[i] for exactly one cycle for each marked slot, together with the masked value decoded as the base. For I/O the base has bits 1..0 cleared, for memory bits 3..0 cleared, and for an unused slot it is 0.
- R8: A sizing probe of all ones to a slot reads back that slot's mask after the apply step.
- R9: A write arriving in the APPLY cycle is laid over the freshly masked value. It marks its slot for the following apply step, while the earlier marks are still reported.
- R10: The sequencer follows the IDLE, BURST and APPLY transitions given above.
- R11: Reset (rst_n low, synchronous) reloads every slot with its reset value from the control inputs and clears all pending flags and rebase pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| cfg_kind | input | 12 | slot kind, 2 bits per slot (0/3 unused, 1 I/O, 2 memory) |
| cfg_size_log2 | input | 30 | log2 of port or page count, 5 bits per slot |
| cfg_base | input | 192 | default base, 32 bits per slot |
| cfg_pref | input | 6 | prefetchable flag per memory slot |
| wr_en | input | 1 | config write strobe |
| wr_last | input | 1 | this write closes the burst |
| wr_dw | input | 6 | dword index of the write |
| wr_be | input | 4 | byte enables |
| wr_data | input | 32 | write data |
| rd_dw | input | 6 | dword index to read |
| rd_data | output | 32 | current slot value, 0 when not a slot |
| rebase_vld | output | 6 | one-cycle rebase pulse per slot |
| rebase_base | output | 192 | decoded base per slot, 32 bits each |

## Verification
The apply step and a new byte write can land on the same slot in the same cycle. This happens when software issues two closing writes to one register back to back. The bench provokes it with a sizing probe immediately followed by a write of a real base. It then judges two things. First, the pulse raised in that cycle must carry the probe's masked base while the register already holds the new raw bytes. Second, a second pulse one cycle later must carry the masked new base.

// File: rtl/bar_pkg.sv
package bar_pkg;

    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_IO   = 2'd1,
        BK_MEM  = 2'd2,
        BK_RSVD = 2'd3
    } bar_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_APPLY = 2'd2
    } seq_state_e;

    // dword index of the first slot (byte offset 0x10)
    localparam int FIRST_SLOT_DW = 4;

    // strip the flag bits from a slot value to get its window base
    function automatic logic [31:0] strip_flags(bar_kind_e k, logic [31:0] v);
        logic [31:0] r;
        unique case (k)
            BK_IO:   r = v & ~32'h3;
            BK_MEM:  r = v & ~32'hF;
            default: r = 32'h0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bar_mask_calc.sv
module bar_mask_calc
    import bar_pkg::*;
#(
    parameter int SZW = 5
) (
    input  bar_kind_e         kind,
    input  logic [SZW-1:0]    size_log2,
    input  logic [31:0]       dflt_base,
    input  logic              pref,
    output logic [31:0]       mask,
    output logic [31:0]       init_val
);
    localparam int PAGE_SHIFT = 12;

    logic [6:0]  shamt;
    logic [63:0] span_m1;

    always_comb begin
        shamt   = 7'(size_log2) + ((kind == BK_MEM) ? 7'(PAGE_SHIFT) : 7'd0);
        span_m1 = (64'd1 << shamt) - 64'd1;
        unique case (kind)
            BK_IO: begin
                mask     = ~span_m1[31:0] | 32'h1;
                init_val = (dflt_base & mask) | 32'h1;
            end
            BK_MEM: begin
                mask     = ~span_m1[31:0] | 32'hF;
                init_val = (dflt_base & mask) | (pref ? 32'h8 : 32'h0);
            end
            default: begin
                mask     = 32'h0;
                init_val = 32'h0;
            end
        endcase
    end
endmodule

// File: rtl/bar_seq_fsm.sv
module bar_seq_fsm
    import bar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_last,
    output logic apply
);
    seq_state_e state_q, state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE, ST_BURST, ST_APPLY: begin
                if (wr_en)                  state_n = wr_last ? ST_APPLY : ST_BURST;
                else if (state_q == ST_APPLY) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
        apply = (state_q == ST_APPLY);
    end

    a_r10_last_to_apply: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_last) |=> (state_q == ST_APPLY));
    a_r10_open_to_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_last) |=> (state_q == ST_BURST));
    a_r10_apply_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY && !wr_en) |=> (state_q == ST_IDLE));
    a_r10_burst_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BURST && !wr_en) |=> (state_q == ST_BURST));
endmodule

// File: rtl/bar_slot.sv
module bar_slot
    import bar_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  bar_kind_e   kind,
    input  logic [31:0] mask,
    input  logic [31:0] init_val,
    input  logic        apply,
    input  logic        wr_en,
    input  logic [5:0]  wr_dw,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output logic [31:0] val,
    output logic        ev,
    output logic [31:0] ev_base
);
    localparam logic [5:0] MY_DW = 6'(FIRST_SLOT_DW + IDX);

    logic [31:0] val_q, val_n, masked;
    logic        flag_q, flag_n, hit;

    always_comb begin
        hit    = wr_en && (wr_dw == MY_DW) && (|wr_be);
        masked = val_q & mask;
        val_n  = (apply && flag_q) ? masked : val_q;
        for (int b = 0; b < 4; b++) begin
            if (hit && wr_be[b]) val_n[8*b +: 8] = wr_data[8*b +: 8];
        end
        flag_n = (apply ? 1'b0 : flag_q) | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q   <= init_val;
            flag_q  <= 1'b0;
            ev      <= 1'b0;
            ev_base <= 32'h0;
        end else begin
            val_q  <= val_n;
            flag_q <= flag_n;
            ev     <= apply && flag_q;
            if (apply && flag_q) ev_base <= strip_flags(kind, masked);
        end
    end

    assign val = val_q;

    a_r6_mask_applied: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && flag_q && !hit) |=> (val_q == ($past(val_q) & $past(mask))));
    a_r5_hold_outside_apply: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply && !hit) |=> $stable(val_q));
    a_r7_pulse_after_apply: assert property (@(posedge clk) disable iff (!rst_n)
        ev |-> ($past(apply) && $past(flag_q)));
    a_r7_base_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && !flag_q) |-> (ev_base == strip_flags(kind, val_q)));
endmodule

// File: rtl/bar_bank.sv
module bar_bank
    import bar_pkg::*;
#(
    parameter int NBAR = 6,
    parameter int SZW  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NBAR*2-1:0]    cfg_kind,
    input  logic [NBAR*SZW-1:0]  cfg_size_log2,
    input  logic [NBAR*32-1:0]   cfg_base,
    input  logic [NBAR-1:0]      cfg_pref,
    input  logic                 wr_en,
    input  logic                 wr_last,
    input  logic [5:0]           wr_dw,
    input  logic [3:0]           wr_be,
    input  logic [31:0]          wr_data,
    input  logic [5:0]           rd_dw,
    output logic [31:0]          rd_data,
    output logic [NBAR-1:0]      rebase_vld,
    output logic [NBAR*32-1:0]   rebase_base
);
    logic        apply;
    logic [31:0] slot_val [NBAR];

    bar_seq_fsm u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_last(wr_last),
        .apply  (apply)
    );

    for (genvar i = 0; i < NBAR; i++) begin : g_slot
        bar_kind_e   kind;
        logic [31:0] mask, init_val;

        assign kind = bar_kind_e'(cfg_kind[2*i +: 2]);

        bar_mask_calc #(.SZW(SZW)) u_mask (
            .kind     (kind),
            .size_log2(cfg_size_log2[SZW*i +: SZW]),
            .dflt_base(cfg_base[32*i +: 32]),
            .pref     (cfg_pref[i]),
            .mask     (mask),
            .init_val (init_val)
        );

        bar_slot #(.IDX(i)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .kind    (kind),
            .mask    (mask),
            .init_val(init_val),
            .apply   (apply),
            .wr_en   (wr_en),
            .wr_dw   (wr_dw),
            .wr_be   (wr_be),
            .wr_data (wr_data),
            .val     (slot_val[i]),
            .ev      (rebase_vld[i]),
            .ev_base (rebase_base[32*i +: 32])
        );
    end

    always_comb begin
        rd_data = 32'h0;
        for (int i = 0; i < NBAR; i++) begin
            if (rd_dw == 6'(FIRST_SLOT_DW + i)) rd_data = slot_val[i];
        end
    end
endmodule

// File: tb/tb_bar_bank.sv
module tb_bar_bank;
    localparam int NBAR = 6;
    localparam int SZW  = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                rst_n;
    logic [NBAR*2-1:0]   cfg_kind;
    logic [NBAR*SZW-1:0] cfg_size_log2;
    logic [NBAR*32-1:0]  cfg_base;
    logic [NBAR-1:0]     cfg_pref;
    logic                wr_en, wr_last;
    logic [5:0]          wr_dw, rd_dw;
    logic [3:0]          wr_be;
    logic [31:0]         wr_data, rd_data;
    logic [NBAR-1:0]     rebase_vld;
    logic [NBAR*32-1:0]  rebase_base;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    bar_bank #(.NBAR(NBAR), .SZW(SZW)) dut (.*);

    // slot setup: kind, log2 size, default base, prefetch
    int          k_tab [NBAR] = '{1, 2, 0, 2, 1, 3};
    int          s_tab [NBAR] = '{5, 4, 0, 0, 2, 0};
    logic [31:0] b_tab [NBAR] = '{32'hC000, 32'hFEB0_0000, 32'h1234, 32'hFEC0_1000, 32'h0E04, 32'h5555};
    logic        p_tab [NBAR] = '{0, 1, 0, 0, 0, 0};

    function automatic logic [31:0] exp_mask(int k, int s);
        if (k == 1) return ~((32'd1 << s) - 32'd1) | 32'h1;
        if (k == 2) return ~((32'd1 << (s + 12)) - 32'd1) | 32'hF;
        return 32'h0;
    endfunction

    function automatic logic [31:0] exp_init(int i);
        logic [31:0] m = exp_mask(k_tab[i], s_tab[i]);
        if (k_tab[i] == 1) return (b_tab[i] & m) | 32'h1;
        if (k_tab[i] == 2) return (b_tab[i] & m) | (p_tab[i] ? 32'h8 : 32'h0);
        return 32'h0;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd(int dw, output logic [31:0] v);
        rd_dw = 6'(dw);
        #1 v = rd_data;
    endtask

    task automatic wr(int dw, logic [3:0] be, logic [31:0] d, bit last);
        @(negedge clk);
        wr_en = 1; wr_dw = 6'(dw); wr_be = be; wr_data = d; wr_last = last;
        @(posedge clk);
        #1 wr_en = 0; wr_last = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] base_of(int i);
        return rebase_base[32*i +: 32];
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rst_n = 0; wr_en = 0; wr_last = 0; wr_dw = 0; wr_be = 0; wr_data = 0; rd_dw = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1;
        for (int i = 0; i < NBAR; i++) begin
            rd(4 + i, v);
            chk((k_tab[i] == 1) ? "R2" : (k_tab[i] == 2) ? "R3" : "R4", "reset value", v, exp_init(i));
        end
        chk("R11", "no pulse after reset", 32'(rebase_vld), 32'h0);
        rd(3, v); chk("R1", "read below slots", v, 32'h0);
    endtask

    task automatic t_probe();
        logic [31:0] v;
        wr(4, 4'hF, 32'hFFFF_FFFF, 1);
        rd(4, v); chk("R5", "probe raw before apply", v, 32'hFFFF_FFFF);
        step();
        rd(4, v); chk("R8", "probe reads mask", v, exp_mask(1, 5));
        chk("R7", "probe pulse", 32'(rebase_vld), 32'h1);
        chk("R7", "io base strip", base_of(0), 32'hFFFF_FFE0);
        step();
        chk("R7", "pulse one cycle", 32'(rebase_vld), 32'h0);
    endtask

    task automatic t_burst();
        logic [31:0] v;
        wr(5, 4'h1, 32'h0000_0078, 0);
        rd(5, v); chk("R5", "partial byte raw", v, 32'hFEB0_0078);
        wr(5, 4'h2, 32'h0000_5600, 0);
        wr(5, 4'h4, 32'h0034_0000, 0);
        wr(5, 4'h8, 32'h1200_0000, 1);
        rd(5, v); chk("R5", "burst raw", v, 32'h1234_5678);
        step();
        rd(5, v); chk("R6", "mem masked", v, 32'h1234_0008);
        chk("R7", "mem pulse", 32'(rebase_vld), 32'h2);
        chk("R7", "mem base strip", base_of(1), 32'h1234_0000);
    endtask

    task automatic t_unused();
        logic [31:0] v;
        wr(6, 4'hF, 32'hFFFF_FFFF, 1);
        step();
        rd(6, v); chk("R4", "unused reads zero", v, 32'h0);
        chk("R7", "unused pulse", 32'(rebase_vld), 32'h4);
        chk("R7", "unused base", base_of(2), 32'h0);
    endtask

    task automatic t_two_slots();
        logic [31:0] v;
        wr(7, 4'hF, 32'hFFFF_FFFF, 0);
        wr(8, 4'hF, 32'h0000_1237, 1);
        step();
        rd(7, v); chk("R8", "mem probe mask", v, exp_mask(2, 0));
        rd(8, v); chk("R2", "io masked", v, 32'h0000_1235);
        chk("R6", "two pulses", 32'(rebase_vld), 32'h18);
        chk("R7", "slot3 base", base_of(3), 32'hFFFF_F000);
        chk("R7", "slot4 base", base_of(4), 32'h0000_1234);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        wr(4, 4'h0, 32'h0, 0);
        wr(10, 4'hF, 32'hFFFF_FFFF, 1);
        step();
        chk("R6", "no marked slot", 32'(rebase_vld), 32'h0);
        rd(4, v); chk("R6", "zero enables leave slot", v, exp_mask(1, 5));
        rd(10, v); chk("R1", "read above slots", v, 32'h0);
    endtask

    task automatic t_overlap();
        logic [31:0] v;
        wr(4, 4'hF, 32'hFFFF_FFFF, 1);
        wr(4, 4'hF, 32'h0000_1234, 1);
        chk("R9", "first pulse", 32'(rebase_vld), 32'h1);
        chk("R9", "first base", base_of(0), 32'hFFFF_FFE0);
        rd(4, v); chk("R9", "new bytes over mask", v, 32'h0000_1234);
        step();
        rd(4, v); chk("R9", "second apply", v, 32'h0000_1220);
        chk("R9", "second pulse", 32'(rebase_vld), 32'h1);
        chk("R9", "second base", base_of(0), 32'h0000_1220);
        step();
        chk("R10", "idle no pulse", 32'(rebase_vld), 32'h0);
    endtask

    task automatic t_rereset();
        logic [31:0] v;
        @(negedge clk) rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1;
        rd(4, v); chk("R11", "slot0 reload", v, exp_init(0));
        rd(5, v); chk("R11", "slot1 reload", v, exp_init(1));
        rd(8, v); chk("R11", "slot4 reload", v, exp_init(4));
        chk("R11", "pulses cleared", 32'(rebase_vld), 32'h0);
    endtask

    initial begin
        for (int i = 0; i < NBAR; i++) begin
            cfg_kind[2*i +: 2]        = 2'(k_tab[i]);
            cfg_size_log2[SZW*i +: SZW] = SZW'(s_tab[i]);
            cfg_base[32*i +: 32]      = b_tab[i];
            cfg_pref[i]               = p_tab[i];
        end
        t_reset();
        t_probe();
        t_burst();
        t_unused();
        t_two_slots();
        t_ignored();
        t_overlap();
        t_rereset();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule